// File: doc/BRIEF.md
# Flash Query-Table Geometry Probe

This block runs once after reset, under control of a start pulse, to discover the layout of a parallel NOR flash device through its standard query table. It drives a simple asynchronous bus master: address, write data, read data, and separate write and read strobes that each stay high for a fixed number of clock cycles. Every table byte is fetched in its own three-cycle bus transaction group. First a query-enter command is written, then the byte is read, then a read-array command is written so the device is never left in query mode between bytes.

The collected bytes are decoded into output registers. These hold the command-set identifier, the device size, the write-buffer size, the number of erase regions (clamped to the slots provided), and for each region the block size, block count, start address and end address. The start and end addresses are accumulated so that the regions tile the address space from zero. A bad signature stops the probe with an error flag. A good run ends with a one-cycle done pulse. All results stay stable until the next start.

The controller has five named states. IDLE waits for start. ENTER issues the query-enter write. READ issues the table read. EXIT issues the read-array write. NEXT decodes the byte. The transitions are: IDLE→ENTER on start; ENTER→READ, READ→EXIT and EXIT→NEXT, each on bus completion; NEXT→ENTER while bytes remain; NEXT→IDLE on the final byte (done) or on a signature mismatch (error).

Top module: `cfi_geom_probe`

## Requirements
- R1: For each table byte the bus performs, in order, a write of 0x98 to word offset 0x55, a read of the table offset, and a write of 0xFF to word offset 0x55. The write and read strobes are never high together, and each strobe pulse lasts exactly WAIT_CYC cycles.
- R2: The bytes at table offsets 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59 ('Q', 'R', 'Y'). On any mismatch err_o rises, no further bus cycle is started, done_o stays low, and err_o holds until the next start, which clears it.
- R3: cmdset_o takes the byte at table offset 0x13 (the value 1 denotes the extended command set).
- R4: dev_size_o equals 2 raised to the byte at offset 0x27, and wbuf_size_o equals 2 raised to the byte at offset 0x2A, both in bytes.
- R5: region_cnt_o takes the byte at offset 0x2C, clamped to NREG. Only that many descriptors are read, so a run reads 7 + 4·region_cnt_o bytes in total.
- R6: The descriptor of region i is the 32-bit little-endian word at offsets 0x2D+4i to 0x30+4i. blk_size_o[i] is 256 times bits 31:16 of that word, and blk_cnt_o[i] is bits 15:0 plus one.
- R7: region_start_o[0] is 0. region_end_o[i] is region_start_o[i] + blk_size_o[i]·blk_cnt_o[i], and region_start_o[i+1] equals region_end_o[i]. Every output of an unused slot is zero.
- R8: done_o is high for exactly one cycle after the final read-array write, with all results already valid. The results hold until the next start, and a start during a run is ignored.
- R9: With BYTE_BUS=1 (the default) every offset appears on fl_addr_o shifted left by one bit (0x55 appears as 0xAA, 0x10 as 0x20). With BYTE_BUS=0 it appears unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a probe (ignored unless idle) |
| done_o | output | 1 | One-cycle pulse: probe complete |
| err_o | output | 1 | Signature mismatch, held until next start |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | 8 | Flash read data |
| cmdset_o | output | 8 | Primary command-set identifier |
| dev_size_o | output | MAP_W | Device size in bytes |
| wbuf_size_o | output | MAP_W | Write-buffer size in bytes |
| region_cnt_o | output | CNT_W | Number of erase regions after clamping |
| blk_size_o | output | NREG×MAP_W | Block size per region |
| blk_cnt_o | output | NREG×MAP_W | Block count per region |
| region_start_o | output | NREG×MAP_W | Region start address |
| region_end_o | output | NREG×MAP_W | Region end address (exclusive) |

## Verification
A step counter that slips shows up straight away as a read at the wrong offset. Within the same run this gives wrong field values, or a read count different from 7 + 4·regions. A bad clamp shows as extra descriptor reads and a corrupted end address for the last slot. A controller that skips the exit write leaves the device model in query mode, which the bus monitor flags at the next array-mode boundary. A stuck state appears as a missing done pulse within a few hundred cycles.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_READ,
        ST_EXIT,
        ST_NEXT
    } probe_state_t;

    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] QRY_PORT   = 8'h55;
    localparam logic [7:0] OFF_SIG    = 8'h10;
    localparam logic [7:0] OFF_CMDSET = 8'h13;
    localparam logic [7:0] OFF_DEVSZ  = 8'h27;
    localparam logic [7:0] OFF_WBUF   = 8'h2A;
    localparam logic [7:0] OFF_NREG   = 8'h2C;
    localparam logic [7:0] OFF_DESC   = 8'h2D;
    localparam logic [7:0] FIXED_STEPS = 8'd7;

    // table offset fetched at a given step of the probe
    function automatic logic [7:0] step_offset(input logic [7:0] s);
        if (s < 8'd3)       return OFF_SIG + s;
        else if (s == 8'd3) return OFF_CMDSET;
        else if (s == 8'd4) return OFF_DEVSZ;
        else if (s == 8'd5) return OFF_WBUF;
        else if (s == 8'd6) return OFF_NREG;
        else                return OFF_DESC + (s - FIXED_STEPS);
    endfunction

    // expected signature character for steps 0..2
    function automatic logic [7:0] sig_char(input logic [7:0] s);
        if (s == 8'd0)      return 8'h51;
        else if (s == 8'd1) return 8'h52;
        else                return 8'h59;
    endfunction

endpackage

// File: rtl/cfi_bus_cycle.sv
module cfi_bus_cycle #(
    parameter int ADDR_W   = 16,
    parameter int WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_wdata_o,
    output logic              fl_we_o,
    output logic              fl_re_o,
    input  logic [7:0]        fl_rdata_i
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    logic             busy_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            wr_q       <= 1'b0;
            cnt_q      <= '0;
            ack_o      <= 1'b0;
            rdata_o    <= '0;
            fl_addr_o  <= '0;
            fl_wdata_o <= '0;
        end else begin
            ack_o <= 1'b0;
            if (!busy_q) begin
                if (req_i) begin
                    busy_q     <= 1'b1;
                    wr_q       <= wr_i;
                    cnt_q      <= '0;
                    fl_addr_o  <= addr_i;
                    fl_wdata_o <= wdata_i;
                end
            end else if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                ack_o  <= 1'b1;
                if (!wr_q) rdata_o <= fl_rdata_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fl_we_o = busy_q & wr_q;
    assign fl_re_o = busy_q & ~wr_q;

    // a new request is only accepted from idle; the controller must never queue one
    p_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> !busy_q);

endmodule

// File: rtl/cfi_region_map.sv
module cfi_region_map #(
    parameter int NREG  = 4,
    parameter int MAP_W = 32,
    parameter int CNT_W = 3
) (
    input  logic [NREG-1:0][31:0]      desc_i,
    input  logic [CNT_W-1:0]           nreg_i,
    output logic [NREG-1:0][MAP_W-1:0] blk_size_o,
    output logic [NREG-1:0][MAP_W-1:0] blk_cnt_o,
    output logic [NREG-1:0][MAP_W-1:0] start_o,
    output logic [NREG-1:0][MAP_W-1:0] end_o
);
    logic [NREG-1:0][MAP_W-1:0] chain_start;
    logic [NREG-1:0][MAP_W-1:0] chain_end;
    logic [NREG-1:0][MAP_W-1:0] bsz;
    logic [NREG-1:0][MAP_W-1:0] bcnt;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [CNT_W-1:0] RIDX = CNT_W'(r);
        logic active;
        assign active  = RIDX < nreg_i;
        assign bsz[r]  = MAP_W'({desc_i[r][31:16], 8'h00});
        assign bcnt[r] = MAP_W'(desc_i[r][15:0]) + MAP_W'(1);
        if (r == 0) begin : g_first
            assign chain_start[r] = '0;
        end else begin : g_rest
            assign chain_start[r] = chain_end[r-1];
        end
        assign chain_end[r]  = chain_start[r] + bsz[r] * bcnt[r];
        assign blk_size_o[r] = active ? bsz[r]         : '0;
        assign blk_cnt_o[r]  = active ? bcnt[r]        : '0;
        assign start_o[r]    = active ? chain_start[r] : '0;
        assign end_o[r]      = active ? chain_end[r]   : '0;
    end

endmodule

// File: rtl/cfi_geom_probe.sv
module cfi_geom_probe
    import cfi_probe_pkg::*;
#(
    parameter int NREG     = 4,
    parameter int ADDR_W   = 16,
    parameter int WAIT_CYC = 3,
    parameter int BYTE_BUS = 1,
    parameter int MAP_W    = 32,
    localparam int CNT_W   = $clog2(NREG + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    output logic                       done_o,
    output logic                       err_o,
    output logic [ADDR_W-1:0]          fl_addr_o,
    output logic [7:0]                 fl_wdata_o,
    output logic                       fl_we_o,
    output logic                       fl_re_o,
    input  logic [7:0]                 fl_rdata_i,
    output logic [7:0]                 cmdset_o,
    output logic [MAP_W-1:0]           dev_size_o,
    output logic [MAP_W-1:0]           wbuf_size_o,
    output logic [CNT_W-1:0]           region_cnt_o,
    output logic [NREG-1:0][MAP_W-1:0] blk_size_o,
    output logic [NREG-1:0][MAP_W-1:0] blk_cnt_o,
    output logic [NREG-1:0][MAP_W-1:0] region_start_o,
    output logic [NREG-1:0][MAP_W-1:0] region_end_o
);
    probe_state_t state_q, state_d;

    logic                  req_q, wr_q, bus_ack;
    logic [7:0]            off_q, wdata_q, bus_rd, rx_q, step_q, idx;
    logic [ADDR_W-1:0]     bus_addr;
    logic [NREG-1:0][31:0] desc_q;
    logic [CNT_W-1:0]      nreg_clamp;
    logic                  sig_bad, last_step;

    // offset-to-address mapping picked by bus width
    if (BYTE_BUS != 0) begin : g_byte_bus
        assign bus_addr = ADDR_W'({off_q, 1'b0});
    end else begin : g_word_bus
        assign bus_addr = ADDR_W'(off_q);
    end

    cfi_bus_cycle #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_q), .wr_i(wr_q), .addr_i(bus_addr), .wdata_i(wdata_q),
        .ack_o(bus_ack), .rdata_o(bus_rd),
        .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
        .fl_we_o(fl_we_o), .fl_re_o(fl_re_o), .fl_rdata_i(fl_rdata_i)
    );

    cfi_region_map #(.NREG(NREG), .MAP_W(MAP_W), .CNT_W(CNT_W)) u_map (
        .desc_i(desc_q), .nreg_i(region_cnt_o),
        .blk_size_o(blk_size_o), .blk_cnt_o(blk_cnt_o),
        .start_o(region_start_o), .end_o(region_end_o)
    );

    assign idx        = step_q - FIXED_STEPS;
    assign nreg_clamp = (int'(rx_q) > NREG) ? CNT_W'(NREG) : CNT_W'(rx_q);
    assign sig_bad    = (step_q < 8'd3) && (rx_q != sig_char(step_q));
    assign last_step  = (step_q == 8'd6) ? (nreg_clamp == '0)
                      : (step_q == 8'(6 + 4 * int'(region_cnt_o)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ENTER;
            ST_ENTER: if (bus_ack) state_d = ST_READ;
            ST_READ:  if (bus_ack) state_d = ST_EXIT;
            ST_EXIT:  if (bus_ack) state_d = ST_NEXT;
            ST_NEXT:  state_d = (sig_bad || last_step) ? ST_IDLE : ST_ENTER;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs, bus requests and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;  wr_q <= 1'b0;  off_q <= '0;  wdata_q <= '0;
            step_q <= '0;   rx_q <= '0;    desc_q <= '0;
            done_o <= 1'b0; err_o <= 1'b0; cmdset_o <= '0;
            dev_size_o <= '0; wbuf_size_o <= '0; region_cnt_o <= '0;
        end else begin
            req_q  <= 1'b0;
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    err_o <= 1'b0;  cmdset_o <= '0;  dev_size_o <= '0;
                    wbuf_size_o <= '0; region_cnt_o <= '0; desc_q <= '0;
                    step_q <= '0;
                    req_q <= 1'b1; wr_q <= 1'b1; wdata_q <= CMD_QUERY; off_q <= QRY_PORT;
                end
                ST_ENTER: if (bus_ack) begin
                    req_q <= 1'b1; wr_q <= 1'b0; off_q <= step_offset(step_q);
                end
                ST_READ: if (bus_ack) begin
                    rx_q  <= bus_rd;
                    req_q <= 1'b1; wr_q <= 1'b1; wdata_q <= CMD_ARRAY; off_q <= QRY_PORT;
                end
                ST_EXIT: ;
                ST_NEXT: begin
                    if (step_q == 8'd3) cmdset_o     <= rx_q;
                    if (step_q == 8'd4) dev_size_o   <= MAP_W'(1) << rx_q;
                    if (step_q == 8'd5) wbuf_size_o  <= MAP_W'(1) << rx_q;
                    if (step_q == 8'd6) region_cnt_o <= nreg_clamp;
                    for (int r = 0; r < NREG; r++)
                        if (step_q >= FIXED_STEPS && int'(idx[7:2]) == r)
                            desc_q[r][{idx[1:0], 3'b000} +: 8] <= rx_q;
                    if (sig_bad) begin
                        err_o <= 1'b1;
                    end else if (last_step) begin
                        done_o <= 1'b1;
                    end else begin
                        step_q <= step_q + 8'd1;
                        req_q <= 1'b1; wr_q <= 1'b1; wdata_q <= CMD_QUERY; off_q <= QRY_PORT;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [7:0] last_cmd_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last_cmd_q <= CMD_ARRAY;
        else if (fl_we_o) last_cmd_q <= fl_wdata_o;
    end

    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_re_o));
    p_cmd_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we_o |-> (fl_wdata_o == CMD_QUERY || fl_wdata_o == CMD_ARRAY));
    p_read_in_query_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re_o |-> last_cmd_q == CMD_QUERY);
    p_array_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || $rose(err_o)) |-> last_cmd_q == CMD_ARRAY);
    p_quiet_after_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !fl_we_o && !fl_re_o);
    p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(region_cnt_o) <= NREG);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

// File: tb/cfi_geom_probe_tb.sv
`timescale 1ns/1ps
module cfi_geom_probe_tb;
    localparam int NREG = 4, ADDR_W = 16, WAIT_CYC = 3, MAP_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, err, we, re;
    logic [ADDR_W-1:0] addr;
    logic [7:0] wdata, rdata, cmdset;
    logic [MAP_W-1:0] dsize, wbsize;
    logic [2:0] rcnt;
    logic [NREG-1:0][MAP_W-1:0] bsz, bcnt, rstart, rend;

    always #2.5 clk = ~clk;

    cfi_geom_probe #(.NREG(NREG), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .MAP_W(MAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .err_o(err),
        .fl_addr_o(addr), .fl_wdata_o(wdata), .fl_we_o(we), .fl_re_o(re),
        .fl_rdata_i(rdata), .cmdset_o(cmdset), .dev_size_o(dsize),
        .wbuf_size_o(wbsize), .region_cnt_o(rcnt), .blk_size_o(bsz),
        .blk_cnt_o(bcnt), .region_start_o(rstart), .region_end_o(rend));

    // ---------------- flash model (8-bit bus, byte address = offset*2) ----------------
    logic [7:0] rom [0:255];
    logic qmode = 1'b0, we_p = 1'b0, re_p = 1'b0;
    int rd_cnt, wr_cnt, proto_bad, run_len;
    logic [ADDR_W-1:0] first_rd_addr;

    assign rdata = qmode ? rom[addr[8:1]] : 8'hEE;

    always @(posedge clk) begin
        we_p <= we; re_p <= re;
        if (we || re) run_len <= run_len + 1;
        else begin
            if ((we_p || re_p) && run_len != WAIT_CYC) proto_bad <= proto_bad + 1;
            run_len <= 0;
        end
        if (we && !we_p) begin
            wr_cnt <= wr_cnt + 1;
            if (addr != 16'h00AA) proto_bad <= proto_bad + 1;
            if (wdata == 8'h98) qmode <= 1'b1;
            else if (wdata == 8'hFF) qmode <= 1'b0;
            else proto_bad <= proto_bad + 1;
        end
        if (re && !re_p) begin
            if (rd_cnt == 0) first_rd_addr <= addr;
            rd_cnt <= rd_cnt + 1;
            if (!qmode) proto_bad <= proto_bad + 1;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_rom(input logic [7:0] c, sz, wb, nr, input logic [3:0][31:0] d);
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        rom[8'h10] = 8'h51; rom[8'h11] = 8'h52; rom[8'h12] = 8'h59;
        rom[8'h13] = c; rom[8'h27] = sz; rom[8'h2A] = wb; rom[8'h2C] = nr;
        for (int r = 0; r < 6; r++)
            for (int b = 0; b < 4; b++)
                rom[8'h2D + 4*r + b] = (r < 4) ? d[3-r][8*b +: 8] : 8'hA5;
    endtask

    int done_seen;
    task automatic run_probe(input bit restart_mid);
        rd_cnt = 0; wr_cnt = 0; proto_bad = 0; done_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (restart_mid && t == 20) start = 1'b1;
            if (restart_mid && t == 21) start = 1'b0;
            if (done) done_seen++;
            if (done_seen > 0 || err) break;
        end
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            if (done) done_seen++;
        end
    endtask

    // stimulus vectors: {cmdset, size exp, wbuf exp, region count, desc0, desc1, desc2, desc3}
    localparam int NV = 4;
    localparam logic [159:0] VEC [NV] = '{
        {8'h01, 8'h16, 8'h05, 8'h01, 32'h0200_003F, 32'h0, 32'h0, 32'h0},
        {8'h01, 8'h15, 8'h06, 8'h02, 32'h0020_0007, 32'h0100_003E, 32'h0, 32'h0},
        {8'h02, 8'h18, 8'h04, 8'h06, 32'h0040_0001, 32'h0080_0002, 32'h0100_0003, 32'h0200_0000},
        {8'h03, 8'h10, 8'h00, 8'h00, 32'h0, 32'h0, 32'h0, 32'h0}
    };

    initial begin
        logic [7:0] c, sz, wb, nr;
        logic [3:0][31:0] d;
        logic [MAP_W-1:0] acc;
        int ne;
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        rd_cnt = 0; wr_cnt = 0; proto_bad = 0; run_len = 0;
        repeat (4) @(negedge clk);
        // reset state
        check(done == 0 && err == 0, "R8 reset done/err", {done, err}, 0);
        check(we == 0 && re == 0, "R1 reset strobes", {we, re}, 0);
        check(cmdset == 0 && rcnt == 0 && dsize == 0, "R8 reset fields", {cmdset, rcnt}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table-driven runs
        for (int v = 0; v < NV; v++) begin
            {c, sz, wb, nr, d} = VEC[v];
            load_rom(c, sz, wb, nr, d);
            run_probe(v == 1);
            ne = (int'(nr) > NREG) ? NREG : int'(nr);
            check(done_seen == 1, "R8 single done pulse", done_seen, 1);
            check(err == 0, "R2 no error on good signature", err, 0);
            check(cmdset == c, "R3 cmdset", cmdset, c);
            check(dsize == (32'd1 << sz), "R4 device size", dsize, 32'd1 << sz);
            check(wbsize == (32'd1 << wb), "R4 write-buffer size", wbsize, 32'd1 << wb);
            check(int'(rcnt) == ne, "R5 clamped region count", rcnt, ne);
            check(rd_cnt == 7 + 4*ne, "R5 read count", rd_cnt, 7 + 4*ne);
            check(wr_cnt == 2*rd_cnt, "R1 two writes per read", wr_cnt, 2*rd_cnt);
            check(proto_bad == 0, "R1 enter/read/exit protocol", proto_bad, 0);
            check(first_rd_addr == 16'h0020, "R9 shifted query address", first_rd_addr, 16'h0020);
            acc = '0;
            for (int r = 0; r < NREG; r++) begin
                logic [MAP_W-1:0] es, ec, e0, e1;
                if (r < ne) begin
                    es = {8'h00, d[3-r][31:16], 8'h00};
                    ec = {16'h0, d[3-r][15:0]} + 1;
                    e0 = acc; e1 = acc + es*ec; acc = e1;
                end else begin
                    es = 0; ec = 0; e0 = 0; e1 = 0;
                end
                check(bsz[r] == es, "R6 block size", bsz[r], es);
                check(bcnt[r] == ec, "R6 block count", bcnt[r], ec);
                check(rstart[r] == e0, "R7 region start", rstart[r], e0);
                check(rend[r] == e1, "R7 region end", rend[r], e1);
            end
        end

        // hold after done: change table, outputs must not move
        rom[8'h13] = 8'h77;
        repeat (30) @(negedge clk);
        check(cmdset == 8'h03 && rcnt == 0, "R8 outputs held", cmdset, 8'h03);

        // bad signature
        load_rom(8'h01, 8'h10, 8'h04, 8'h01, {32'h0100_0000, 96'h0});
        rom[8'h11] = 8'h58;
        run_probe(1'b0);
        check(err == 1, "R2 error raised", err, 1);
        check(done_seen == 0, "R2 no done on error", done_seen, 0);
        check(rd_cnt == 2, "R2 stop after bad byte", rd_cnt, 2);
        check(cmdset == 0, "R2 fields cleared", cmdset, 0);
        repeat (20) @(negedge clk);
        check(err == 1 && rd_cnt == 2, "R2 error held, bus quiet", {err, 8'(rd_cnt)}, 9'h102);

        // restart clears error
        rom[8'h11] = 8'h52;
        run_probe(1'b0);
        check(err == 0 && done_seen == 1, "R2 start clears error", {err, 8'(done_seen)}, 1);
        check(bsz[0] == 32'h10000, "R6 block size after restart", bsz[0], 32'h10000);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule